// File: doc/BRIEF.md
# Brightness Register Command Decoder

This block is the byte-level transaction layer of a serial two-wire (I2C) target that drives sixteen brightness channels. A bit-level engine underneath it reports bus START and STOP events, delivers each received byte with a one-cycle strobe, and asks for the next byte to send whenever the controller reads. The decoder matches the first byte after a START against the device's own address and a shared all-call address. It then interprets a register-address byte, writes or returns brightness values and a guarded mode register, and decides for every byte whether an acknowledge goes back.

The own address is `101` followed by four strap inputs. A separate address, `1011000`, addresses every device on the bus at once, and a bit in the mode register turns that response off. The register-address byte combines a step code with a register index, so one transaction can walk through the brightness bank. Writes to the mode register are checked against two guard bits and are held back until the closing STOP, which also lets a single accepted write put the device back to its power-on state. A strap input selects a write-only wiring of the data line: with it low, the block never returns an acknowledge or read data, but it still applies writes.

Top module: `lumreg_cmd_decoder`

## Requirements
- R1: The first byte after a START hits when bits 7..1 equal `1,0,1,strap[3:0]`. Bit 0 set means read and bit 0 clear means write. A hit is acknowledged. A miss is not acknowledged, and every byte up to the next START or STOP is then neither acknowledged nor applied.
- R2: Address `1011000` is acknowledged and behaves like the own address while mode bit 0 (all-call enable) is 1. While that bit is 0 it is not acknowledged.
- R3: Address `1011011` never hits as an own address, not even when the straps form it.
- R4: In the register-address byte, bits 7..5 are a step code and bits 4..0 are an index. With code `000`, every data byte goes to the same brightness register (index 00h–0Fh).
- R5: With code `001`, the brightness index advances by one after each data byte written or read, and it wraps from 0Fh to 00h.
- R6: Data bytes are acknowledged but change nothing when the step code is not `000` or `001`, or when the index is neither a brightness index nor a mode-register selection. The mode register is selected only by the full byte 1Ah, so 3Ah selects nothing. A read of a non-selection returns 00h.
- R7: A mode data byte is accepted only when bit 6 is 0 and bit 1 is 1. Any other byte is discarded.
- R8: An accepted mode byte reaches `mode_o` only at the next STOP. `pwm_slow` follows mode bit 3 and `allcall_en` follows mode bit 0.
- R9: After reset, every brightness register reads 00h and the mode register reads 03h.
- R10: If an accepted mode byte has bit 7 set, the STOP returns all brightness registers to 00h and the mode register to 03h.
- R11: While `bidir_en` is low, `ack_o` and `rd_vld` stay low. Writes are still applied.
- R12: `ack_o` pulses in the cycle after `byte_vld`. `rd_vld` and `rd_data` appear in the cycle after `rd_req`. A written value shows on `bright_o` in the cycle after its byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_strap | input | 4 | Low four bits of the own address |
| bidir_en | input | 1 | 1: data line bidirectional, 0: write-only |
| bus_start | input | 1 | START or repeated START seen (pulse) |
| bus_stop | input | 1 | STOP seen (pulse) |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received byte |
| rd_req | input | 1 | Engine requests the next read byte (pulse) |
| ack_o | output | 1 | Acknowledge decision for the last byte (pulse) |
| rd_vld | output | 1 | Read byte valid (pulse) |
| rd_data | output | 8 | Read byte |
| bright_o | output | 128 | Brightness registers, channel n at bits 8n+7..8n |
| pwm_slow | output | 1 | Slow PWM period selected |
| allcall_en | output | 1 | All-call response enabled |
| mode_o | output | 8 | Committed mode register |

## Verification
The hardest situation to reach is a mode byte that has been accepted but not yet committed. It sits in a staging register that the ports cannot see until STOP. The bench writes a valid mode byte, samples `mode_o` and `pwm_slow` before it issues the STOP and again after it, and uses a mode byte with bit 7 set to prove that the reset effect also waits for STOP. Reserved-address rejection requires strap values that spell the reserved address, so the bench changes the straps in the middle of the run.

// File: rtl/lumreg_pkg.sv
package lumreg_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 5;

    localparam logic [6:0] ADDR_PREFIX_HI = 3'b101 << 4;
    localparam logic [6:0] ALLCALL_ADDR   = 7'b1011000;
    localparam logic [6:0] SWRST_ADDR     = 7'b1011011;

    localparam logic [2:0] STEP_NONE = 3'b000;
    localparam logic [2:0] STEP_INC  = 3'b001;

    localparam logic [7:0] MODE_SEL_BYTE = 8'h1A;
    localparam logic [7:0] MODE_RST_VAL  = 8'h03;

    localparam int MODE_LIMIT_BIT = 7;
    localparam int MODE_GUARD0    = 6;
    localparam int MODE_SLOW_BIT  = 3;
    localparam int MODE_GUARD1    = 1;
    localparam int MODE_ALL_BIT   = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } dec_state_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_BRIGHT,
        TGT_MODE
    } tgt_e;
endpackage

// File: rtl/lumreg_addr_match.sv
module lumreg_addr_match
    import lumreg_pkg::*;
(
    input  logic [6:0] addr7,
    input  logic [3:0] strap,
    input  logic       allcall_en,
    output logic       own_hit,
    output logic       all_hit
);
    logic [6:0] own_addr;

    always_comb begin
        own_addr = ADDR_PREFIX_HI | {3'b000, strap};
        own_hit  = (addr7 == own_addr) && (own_addr != SWRST_ADDR);
        all_hit  = allcall_en && (addr7 == ALLCALL_ADDR);
    end
endmodule

// File: rtl/lumreg_regfile.sv
module lumreg_regfile
    import lumreg_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CH_W-1:0]                wr_idx,
    input  logic [BYTE_W-1:0]              wr_data,
    input  logic                           commit,
    input  logic [BYTE_W-1:0]              commit_val,
    input  logic [CH_W-1:0]                rd_idx,
    output logic [BYTE_W-1:0]              rd_bright,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  bright_arr,
    output logic [BYTE_W-1:0]              mode_q
);
    typedef struct packed {
        logic [NUM_CH-1:0][BYTE_W-1:0] bright;
        logic [BYTE_W-1:0]             mode;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (commit) begin
            if (commit_val[MODE_LIMIT_BIT]) begin
                rf_d.bright = '0;
                rf_d.mode   = MODE_RST_VAL;
            end else begin
                rf_d.mode   = commit_val;
            end
        end else if (wr_en) begin
            rf_d.bright[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.bright <= '0;
            rf_q.mode   <= MODE_RST_VAL;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd_bright  = rf_q.bright[rd_idx];
    assign bright_arr = rf_q.bright;
    assign mode_q     = rf_q.mode;
endmodule

// File: rtl/lumreg_cmd_fsm.sv
module lumreg_cmd_fsm
    import lumreg_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bidir_en,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd_req,
    input  logic              own_hit,
    input  logic              all_hit,
    input  logic [BYTE_W-1:0] rd_bright,
    input  logic [BYTE_W-1:0] mode_q,
    output logic [CH_W-1:0]   ptr,
    output logic              wr_en,
    output logic              commit,
    output logic [BYTE_W-1:0] commit_val,
    output logic              ack_o,
    output logic              rd_vld,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    typedef struct packed {
        dec_state_e        st;
        tgt_e              tgt;
        logic              step;
        logic [CH_W-1:0]   ptr;
        logic              pend;
        logic [BYTE_W-1:0] pend_val;
        logic              ack;
        logic              rvld;
        logic [BYTE_W-1:0] rdat;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [2:0]       step_code;
    logic [IDX_W-1:0] reg_idx;
    logic             idx_is_bright;
    logic             mode_byte_ok;
    logic [CH_W-1:0]  ptr_next;

    always_comb begin
        step_code     = byte_in[7:5];
        reg_idx       = byte_in[IDX_W-1:0];
        idx_is_bright = (int'(reg_idx) < NUM_CH);
        mode_byte_ok  = !byte_in[MODE_GUARD0] && byte_in[MODE_GUARD1];
        ptr_next      = (s_q.ptr == LAST_CH) ? '0 : s_q.ptr + 1'b1;
    end

    always_comb begin
        s_d        = s_q;
        s_d.ack    = 1'b0;
        s_d.rvld   = 1'b0;
        wr_en      = 1'b0;
        commit     = 1'b0;
        commit_val = s_q.pend_val;

        if (bus_stop) begin
            s_d.st   = ST_IDLE;
            commit   = s_q.pend;
            s_d.pend = 1'b0;
        end else if (bus_start) begin
            s_d.st = ST_ADDR;
        end else if (byte_vld) begin
            unique case (s_q.st)
                ST_ADDR: begin
                    if (own_hit || all_hit) begin
                        s_d.ack = 1'b1;
                        s_d.st  = byte_in[0] ? ST_RDATA : ST_REG;
                    end else begin
                        s_d.st  = ST_SKIP;
                    end
                end
                ST_REG: begin
                    s_d.ack  = 1'b1;
                    s_d.st   = ST_WDATA;
                    s_d.ptr  = reg_idx[CH_W-1:0];
                    s_d.step = (step_code == STEP_INC);
                    if (byte_in == MODE_SEL_BYTE) begin
                        s_d.tgt = TGT_MODE;
                    end else if (((step_code == STEP_NONE) || (step_code == STEP_INC))
                                 && idx_is_bright) begin
                        s_d.tgt = TGT_BRIGHT;
                    end else begin
                        s_d.tgt = TGT_NONE;
                    end
                end
                ST_WDATA: begin
                    s_d.ack = 1'b1;
                    if (s_q.tgt == TGT_BRIGHT) begin
                        wr_en = 1'b1;
                        if (s_q.step) s_d.ptr = ptr_next;
                    end else if ((s_q.tgt == TGT_MODE) && mode_byte_ok) begin
                        s_d.pend     = 1'b1;
                        s_d.pend_val = byte_in;
                    end
                end
                default: ;
            endcase
        end else if (rd_req && (s_q.st == ST_RDATA)) begin
            s_d.rvld = 1'b1;
            unique case (s_q.tgt)
                TGT_BRIGHT: begin
                    s_d.rdat = rd_bright;
                    if (s_q.step) s_d.ptr = ptr_next;
                end
                TGT_MODE: s_d.rdat = mode_q;
                default:  s_d.rdat = '0;
            endcase
        end

        if (!bidir_en) begin
            s_d.ack  = 1'b0;
            s_d.rvld = 1'b0;
            s_d.rdat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st       <= ST_IDLE;
            s_q.tgt      <= TGT_NONE;
            s_q.step     <= 1'b0;
            s_q.ptr      <= '0;
            s_q.pend     <= 1'b0;
            s_q.pend_val <= MODE_RST_VAL;
            s_q.ack      <= 1'b0;
            s_q.rvld     <= 1'b0;
            s_q.rdat     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr     = s_q.ptr;
    assign ack_o   = s_q.ack;
    assign rd_vld  = s_q.rvld;
    assign rd_data = s_q.rdat;
endmodule

// File: rtl/lumreg_cmd_decoder.sv
module lumreg_cmd_decoder
    import lumreg_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int BR_W = NUM_CH * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr_strap,
    input  logic              bidir_en,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd_req,
    output logic              ack_o,
    output logic              rd_vld,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BR_W-1:0]   bright_o,
    output logic              pwm_slow,
    output logic              allcall_en,
    output logic [BYTE_W-1:0] mode_o
);
    logic                          own_hit, all_hit;
    logic [CH_W-1:0]               ptr;
    logic                          wr_en, commit;
    logic [BYTE_W-1:0]             commit_val, rd_bright, mode_q;
    logic [NUM_CH-1:0][BYTE_W-1:0] bright_arr;

    lumreg_addr_match u_match (
        .addr7      (byte_in[7:1]),
        .strap      (addr_strap),
        .allcall_en (mode_q[MODE_ALL_BIT]),
        .own_hit    (own_hit),
        .all_hit    (all_hit)
    );

    lumreg_cmd_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bidir_en   (bidir_en),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .rd_req     (rd_req),
        .own_hit    (own_hit),
        .all_hit    (all_hit),
        .rd_bright  (rd_bright),
        .mode_q     (mode_q),
        .ptr        (ptr),
        .wr_en      (wr_en),
        .commit     (commit),
        .commit_val (commit_val),
        .ack_o      (ack_o),
        .rd_vld     (rd_vld),
        .rd_data    (rd_data)
    );

    lumreg_regfile #(.NUM_CH(NUM_CH)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (ptr),
        .wr_data    (byte_in),
        .commit     (commit),
        .commit_val (commit_val),
        .rd_idx     (ptr),
        .rd_bright  (rd_bright),
        .bright_arr (bright_arr),
        .mode_q     (mode_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
        assign bright_o[g*BYTE_W +: BYTE_W] = bright_arr[g];
    end

    assign mode_o     = mode_q;
    assign pwm_slow   = mode_q[MODE_SLOW_BIT];
    assign allcall_en = mode_q[MODE_ALL_BIT];
endmodule

// File: rtl/lumreg_cmd_decoder_chk.sv
module lumreg_cmd_decoder_chk #(
    parameter int BR_W = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bidir_en,
    input logic            bus_stop,
    input logic            byte_vld,
    input logic            rd_req,
    input logic            ack_o,
    input logic            rd_vld,
    input logic [7:0]      mode_o,
    input logic [BR_W-1:0] bright_o
);
    // R11
    a_r11_quiet_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bidir_en) |-> (!ack_o && !rd_vld));

    // R12
    a_r12_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(byte_vld));

    // R12
    a_r12_rdata_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_req));

    // R8
    a_r8_mode_moves_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> $past(bus_stop));

    // R10
    a_r10_bright_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bright_o) |-> ($past(byte_vld) || $past(bus_stop)));
endmodule

bind lumreg_cmd_decoder lumreg_cmd_decoder_chk #(.BR_W(BR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bidir_en (bidir_en),
    .bus_stop (bus_stop),
    .byte_vld (byte_vld),
    .rd_req   (rd_req),
    .ack_o    (ack_o),
    .rd_vld   (rd_vld),
    .mode_o   (mode_o),
    .bright_o (bright_o)
);

// File: tb/lumreg_cmd_decoder_bench.sv
module lumreg_cmd_decoder_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   addr_strap = 4'b0101;
    logic         bidir_en = 1'b1;
    logic         bus_start = 1'b0;
    logic         bus_stop = 1'b0;
    logic         byte_vld = 1'b0;
    logic [7:0]   byte_in = 8'h00;
    logic         rd_req = 1'b0;
    logic         ack_o, rd_vld, pwm_slow, allcall_en;
    logic [7:0]   rd_data, mode_o;
    logic [127:0] bright_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] OWN_W = 8'hAA;
    localparam logic [7:0] OWN_R = 8'hAB;

    always #10 clk = ~clk;

    lumreg_cmd_decoder u_lumreg_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .bidir_en(bidir_en),
        .bus_start(bus_start), .bus_stop(bus_stop), .byte_vld(byte_vld),
        .byte_in(byte_in), .rd_req(rd_req), .ack_o(ack_o), .rd_vld(rd_vld),
        .rd_data(rd_data), .bright_o(bright_o), .pwm_slow(pwm_slow),
        .allcall_en(allcall_en), .mode_o(mode_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ch(int i);
        return bright_o[i*8 +: 8];
    endfunction

    task automatic go_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic go_stop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic put(logic [7:0] b, logic exp_ack, string req);
        byte_in = b; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        check(req, ack_o, exp_ack);
    endtask

    task automatic get(logic exp_vld, logic [7:0] exp, string req);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(req, rd_vld, exp_vld);
        check(req, rd_data, exp);
    endtask

    task automatic wr1(logic [7:0] regb, logic [7:0] d);
        go_start(); put(OWN_W, 1, "R1"); put(regb, 1, "R4"); put(d, 1, "R4"); go_stop();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) check("R9", ch(i), 0);
        check("R9", mode_o, 8'h03);
        check("R9", ack_o, 0);
    endtask

    task automatic t_own_rw();
        wr1(8'h03, 8'h7F);
        check("R1", ch(3), 8'h7F);
        go_start(); put(OWN_W, 1, "R1"); put(8'h03, 1, "R1");
        go_start(); put(OWN_R, 1, "R1"); get(1, 8'h7F, "R12"); go_stop();
    endtask

    task automatic t_miss();
        go_start(); put(8'hA2, 0, "R1"); put(8'h05, 0, "R1"); put(8'h11, 0, "R1"); go_stop();
        check("R1", ch(5), 0);
    endtask

    task automatic t_no_step();
        go_start(); put(OWN_W, 1, "R4"); put(8'h02, 1, "R4");
        put(8'h11, 1, "R4"); put(8'h22, 1, "R4"); go_stop();
        check("R4", ch(2), 8'h22);
        check("R4", ch(4), 0);
    endtask

    task automatic t_step_wrap();
        go_start(); put(OWN_W, 1, "R5"); put(8'h2E, 1, "R5");
        put(8'h01, 1, "R5"); put(8'h02, 1, "R5"); put(8'h03, 1, "R5"); go_stop();
        check("R5", ch(14), 1); check("R5", ch(15), 2); check("R5", ch(0), 3);
        go_start(); put(OWN_W, 1, "R5"); put(8'h2E, 1, "R5");
        go_start(); put(OWN_R, 1, "R5");
        get(1, 8'h01, "R5"); get(1, 8'h02, "R5"); get(1, 8'h03, "R5"); go_stop();
    endtask

    task automatic t_bad_target();
        go_start(); put(OWN_W, 1, "R6"); put(8'h44, 1, "R6"); put(8'h99, 1, "R6"); go_stop();
        check("R6", ch(4), 0);
        go_start(); put(OWN_W, 1, "R6"); put(8'h12, 1, "R6"); put(8'h98, 1, "R6"); go_stop();
        for (int i = 0; i < 16; i++) check("R6", ch(i) == 8'h98, 0);
        go_start(); put(OWN_W, 1, "R6"); put(8'h3A, 1, "R6"); put(8'h0B, 1, "R6"); go_stop();
        check("R6", mode_o, 8'h03);
        go_start(); put(OWN_W, 1, "R6"); put(8'h12, 1, "R6");
        go_start(); put(OWN_R, 1, "R6"); get(1, 8'h00, "R6"); go_stop();
    endtask

    task automatic t_mode_guard();
        go_start(); put(OWN_W, 1, "R7"); put(8'h1A, 1, "R7");
        put(8'h42, 1, "R7"); put(8'h08, 1, "R7"); go_stop();
        check("R7", mode_o, 8'h03);
    endtask

    task automatic t_mode_at_stop();
        go_start(); put(OWN_W, 1, "R8"); put(8'h1A, 1, "R8"); put(8'h0A, 1, "R8");
        check("R8", mode_o, 8'h03);
        check("R8", pwm_slow, 0);
        go_stop();
        check("R8", mode_o, 8'h0A);
        check("R8", pwm_slow, 1);
        check("R8", allcall_en, 0);
        go_start(); put(OWN_W, 1, "R8"); put(8'h1A, 1, "R8");
        go_start(); put(OWN_R, 1, "R8"); get(1, 8'h0A, "R8"); go_stop();
    endtask

    task automatic t_allcall();
        go_start(); put(8'hB0, 0, "R2"); put(8'h01, 0, "R2"); put(8'h66, 0, "R2"); go_stop();
        check("R2", ch(1), 0);
        wr1(8'h1A, 8'h03);
        check("R2", allcall_en, 1);
        go_start(); put(8'hB0, 1, "R2"); put(8'h01, 1, "R2"); put(8'h33, 1, "R2"); go_stop();
        check("R2", ch(1), 8'h33);
    endtask

    task automatic t_reserved();
        addr_strap = 4'b1011;
        go_start(); put(8'hB6, 0, "R3"); put(8'h06, 0, "R3"); put(8'h5E, 0, "R3"); go_stop();
        check("R3", ch(6), 0);
        addr_strap = 4'b0101;
    endtask

    task automatic t_limit();
        wr1(8'h07, 8'h44);
        check("R10", ch(7), 8'h44);
        go_start(); put(OWN_W, 1, "R10"); put(8'h1A, 1, "R10"); put(8'h82, 1, "R10");
        check("R10", ch(7), 8'h44);
        go_stop();
        check("R10", ch(7), 0);
        check("R10", ch(3), 0);
        check("R10", mode_o, 8'h03);
    endtask

    task automatic t_write_only();
        bidir_en = 1'b0;
        go_start(); put(OWN_W, 0, "R11"); put(8'h09, 0, "R11"); put(8'h5C, 0, "R11"); go_stop();
        check("R11", ch(9), 8'h5C);
        go_start(); put(OWN_W, 0, "R11"); put(8'h09, 0, "R11");
        go_start(); put(OWN_R, 0, "R11"); get(0, 8'h00, "R11"); go_stop();
        bidir_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_own_rw();
        t_miss();
        t_no_step();
        t_step_wrap();
        t_bad_target();
        t_mode_guard();
        t_mode_at_stop();
        t_allcall();
        t_reserved();
        t_limit();
        t_write_only();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule